// File: doc/BRIEF.md
# Legacy Memory Window Router

This block sits in a host bridge. It looks at every CPU memory request and decides whether it goes to DRAM or to the PCI bus. For DRAM it also gives the offset inside the DRAM array. The split follows a fixed top-of-low-memory boundary. Below that boundary, addresses go to RAM at the same offset. From the boundary up to 4 GiB is the PCI hole. Above 4 GiB, RAM resumes, carrying the memory that the hole hides. Past the end of installed memory, requests go to PCI.

The legacy area below 1 MiB can be reprogrammed through a byte-wide configuration port. Each option-ROM window of 16 KiB and the 64 KiB BIOS window carry a 2-bit attribute. The attribute sends the window to RAM, to read-only RAM, or to PCI. A write to a read-only window is dropped, and RAM is not written. The 128 KiB graphics window goes to PCI unless a control register opens it to RAM, either always or only while the system-management input is high. Every decision is registered and appears one cycle after the request.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset, every attribute register and the SMRAM control register hold 0. All three outputs are idle (valid 0, target 0, RAM address 0, drop 0). Requests to 0xA0000, 0xC0000 and 0xF0000 route to PCI.
- R2: `rsp_valid` equals `req_valid` of the previous cycle. The target code on `rsp_tgt` is 0 = none, 1 = RAM, 2 = PCI. When `rsp_valid` is 0, `rsp_tgt`, `rsp_ram_addr` and `rsp_wr_drop` are all 0. For any response not routed to RAM, `rsp_ram_addr` is 0.
- R3: Addresses below TOLM route to RAM at the same offset. This holds outside 0xA0000–0xFFFFF, including the whole range below 0xA0000.
- R4: Addresses from TOLM up to 0xFFFF_FFFF route to PCI.
- R5: Addresses from 4 GiB up to HIGH_END−1 route to RAM at address − 4 GiB + TOLM. Addresses at HIGH_END and above route to PCI.
- R6: The attribute encoding is as follows. Code 3 routes reads and writes to RAM at the same offset. Code 1 routes reads to RAM at the same offset. Codes 0 and 2 route reads and writes to PCI.
- R7: A write to a window with attribute 1 gives target 0 with `rsp_wr_drop` = 1 and RAM address 0. No other response asserts `rsp_wr_drop`.
- R8: Configuration register index 0, bits [5:4], governs 0xF0000–0xFFFFF. Window i (0..11) covers 0xC0000 + 0x4000·i for 16 KiB. It is governed by register index 1 + i/2: bits [1:0] when i is even, bits [5:4] when i is odd. The other bits of these registers have no effect on routing.
- R9: Register index 7 is the SMRAM control. The window 0xA0000–0xBFFFF routes to RAM at the same offset when (`smm` = 1 and bit 3 = 1) or bit 6 = 1. Otherwise it routes to PCI. The legacy windows override the TOLM split.
- R10: A configuration write (`cfg_we` = 1) takes effect for requests presented on the next cycle. A request presented in the same cycle as the write is routed with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| smm | input | 1 | System-management mode active |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | 3 | Configuration register index (0–6 attributes, 7 SMRAM control) |
| cfg_data | input | 8 | Configuration byte |
| rsp_valid | output | 1 | Routed response valid |
| rsp_tgt | output | 2 | Target: 0 none, 1 RAM, 2 PCI |
| rsp_ram_addr | output | ADDR_W | DRAM offset when target is RAM |
| rsp_wr_drop | output | 1 | Write to read-only window dropped |

## Verification
The checker tests these properties on every cycle:
- the one-cycle valid relation and the quiet idle response;
- same-offset RAM routing below 0xA0000;
- PCI routing of the hole and of everything above HIGH_END;
- dropped responses only for writes, with no target.

Some behaviour depends on programmed state, so only the bench's scenarios can show it:
- attribute field placement, for both even and odd windows and for the BIOS field;
- the effect of the unused register bits;
- read-only behaviour on reads versus writes;
- the SMRAM gating against `smm`;
- the remap offset above 4 GiB;
- the next-cycle timing of a configuration write against a request in the same cycle.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_PCI  = 2'd2
  } tgt_e;

  localparam int unsigned CFG_DW    = 8;
  localparam int unsigned CFG_NREG  = 8;
  localparam int unsigned CFG_IW    = $clog2(CFG_NREG);
  localparam int unsigned ROM_WINS  = 12;
  localparam int unsigned SMRAM_IDX = 7;

  localparam logic [1:0] ATTR_RW = 2'd3;
  localparam logic [1:0] ATTR_RO = 2'd1;
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
  import lmr_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [CFG_IW-1:0]                idx,
  input  logic [CFG_DW-1:0]                data,
  output logic [CFG_NREG-1:0][CFG_DW-1:0]  regs_o
);
  logic [CFG_NREG-1:0][CFG_DW-1:0] regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (we) regs_d[idx] = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  regs_q <= '0;
    else if (we) regs_q <= regs_d;
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/lmr_attr_lookup.sv
module lmr_attr_lookup
  import lmr_pkg::*;
(
  input  logic [19:0]                      low_addr,
  input  logic [CFG_NREG-1:0][CFG_DW-1:0]  regs,
  output logic                             win_hit,
  output logic [1:0]                       attr
);
  logic [ROM_WINS-1:0][1:0] rom_fld;
  logic                     in_bios, in_rom;

  for (genvar i = 0; i < int'(ROM_WINS); i++) begin : g_fld
    assign rom_fld[i] = regs[1 + i/2][(i%2)*4 +: 2];
  end

  assign in_bios = (low_addr[19:16] == 4'hF);
  assign in_rom  = (low_addr[19:18] == 2'b11) && (low_addr[17:16] != 2'b11);
  assign win_hit = in_bios || in_rom;

  always_comb begin
    attr = 2'd0;
    if (in_bios) begin
      attr = regs[0][5:4];
    end else begin
      for (int i = 0; i < int'(ROM_WINS); i++) begin
        if (in_rom && (low_addr[17:14] == 4'(i))) attr = rom_fld[i];
      end
    end
  end
endmodule

// File: rtl/lmr_route.sv
module lmr_route
  import lmr_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 40,
  parameter logic [ADDR_W-1:0]   TOLM     = 40'h00_E000_0000,
  parameter logic [ADDR_W-1:0]   HIGH_END = 40'h01_2000_0000
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               write,
  input  logic               smm,
  input  logic [CFG_DW-1:0]  smram_ctl,
  input  logic               win_hit,
  input  logic [1:0]         attr,
  output tgt_e               tgt,
  output logic               drop,
  output logic [ADDR_W-1:0]  ram_addr
);
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);

  logic below_1m, in_vga, smram_open;

  assign below_1m   = (addr[ADDR_W-1:20] == '0);
  assign in_vga     = below_1m && (addr[19:17] == 3'b101);
  assign smram_open = (smm && smram_ctl[3]) || smram_ctl[6];

  always_comb begin
    tgt      = TGT_PCI;
    drop     = 1'b0;
    ram_addr = '0;
    if (in_vga) begin
      if (smram_open) begin
        tgt      = TGT_RAM;
        ram_addr = addr;
      end
    end else if (below_1m && win_hit) begin
      if (attr == ATTR_RW) begin
        tgt      = TGT_RAM;
        ram_addr = addr;
      end else if (attr == ATTR_RO) begin
        if (write) begin
          tgt  = TGT_NONE;
          drop = 1'b1;
        end else begin
          tgt      = TGT_RAM;
          ram_addr = addr;
        end
      end
    end else if (addr < TOLM) begin
      tgt      = TGT_RAM;
      ram_addr = addr;
    end else if (addr >= FOUR_G && addr < HIGH_END) begin
      tgt      = TGT_RAM;
      ram_addr = addr - FOUR_G + TOLM;
    end
  end
endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
  import lmr_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 40,
  parameter logic [ADDR_W-1:0]   TOLM     = 40'h00_E000_0000,
  parameter logic [ADDR_W-1:0]   HIGH_END = 40'h01_2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              smm,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [7:0]        cfg_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_tgt,
  output logic [ADDR_W-1:0] rsp_ram_addr,
  output logic              rsp_wr_drop
);
  logic [CFG_NREG-1:0][CFG_DW-1:0] regs;
  logic                            win_hit;
  logic [1:0]                      attr;
  tgt_e                            dec_tgt;
  logic                            dec_drop;
  logic [ADDR_W-1:0]               dec_addr;

  lmr_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .data  (cfg_data),
    .regs_o(regs)
  );

  lmr_attr_lookup u_attr (
    .low_addr(req_addr[19:0]),
    .regs    (regs),
    .win_hit (win_hit),
    .attr    (attr)
  );

  lmr_route #(.ADDR_W(ADDR_W), .TOLM(TOLM), .HIGH_END(HIGH_END)) u_route (
    .addr     (req_addr),
    .write    (req_write),
    .smm      (smm),
    .smram_ctl(regs[SMRAM_IDX]),
    .win_hit  (win_hit),
    .attr     (attr),
    .tgt      (dec_tgt),
    .drop     (dec_drop),
    .ram_addr (dec_addr)
  );

  logic              vld_q, vld_d;
  logic [1:0]        tgt_q, tgt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              drop_q, drop_d;

  always_comb begin
    vld_d  = req_valid;
    tgt_d  = 2'd0;
    addr_d = '0;
    drop_d = 1'b0;
    if (req_valid) begin
      tgt_d  = dec_tgt;
      addr_d = dec_addr;
      drop_d = dec_drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tgt_q  <= 2'd0;
      addr_q <= '0;
      drop_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      tgt_q  <= tgt_d;
      addr_q <= addr_d;
      drop_q <= drop_d;
    end
  end

  assign rsp_valid    = vld_q;
  assign rsp_tgt      = tgt_q;
  assign rsp_ram_addr = addr_q;
  assign rsp_wr_drop  = drop_q;
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker #(
  parameter int unsigned         ADDR_W   = 40,
  parameter logic [ADDR_W-1:0]   TOLM     = 40'h00_E000_0000,
  parameter logic [ADDR_W-1:0]   HIGH_END = 40'h01_2000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              smm,
  input logic              cfg_we,
  input logic [2:0]        cfg_idx,
  input logic [7:0]        cfg_data,
  input logic              rsp_valid,
  input logic [1:0]        rsp_tgt,
  input logic [ADDR_W-1:0] rsp_ram_addr,
  input logic              rsp_wr_drop
);
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);
  localparam logic [ADDR_W-1:0] VGA_LO = ADDR_W'(32'h000A_0000);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_valid == $past(req_valid)));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_tgt == 2'd0 && rsp_ram_addr == '0 && !rsp_wr_drop));

  assert_low_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_valid) && $past(req_addr) < VGA_LO)
      |-> (rsp_tgt == 2'd1 && rsp_ram_addr == $past(req_addr)));

  assert_hole_pci_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_valid) && $past(req_addr) >= TOLM && $past(req_addr) < FOUR_G)
      |-> (rsp_tgt == 2'd2 && rsp_ram_addr == '0));

  assert_above_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(req_valid) && $past(req_addr) >= HIGH_END)
      |-> (rsp_tgt == 2'd2));

  assert_drop_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_wr_drop) |-> ($past(req_write) && rsp_tgt == 2'd0 && rsp_ram_addr == '0));
endmodule

bind legacy_mem_router lmr_checker #(
  .ADDR_W(ADDR_W), .TOLM(TOLM), .HIGH_END(HIGH_END)
) chk_i (.*);

// File: tb/legacy_mem_router_tb_top.sv
module legacy_mem_router_tb_top;
  localparam int unsigned  AW      = 40;
  localparam logic [39:0]  TOLM_TB = 40'h00_E000_0000;
  localparam logic [39:0]  HEND_TB = 40'h01_2000_0000;
  localparam longint unsigned G4   = 64'h1_0000_0000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, smm, cfg_we;
  logic [AW-1:0] req_addr;
  logic [2:0]    cfg_idx;
  logic [7:0]    cfg_data;
  logic          rsp_valid, rsp_wr_drop;
  logic [1:0]    rsp_tgt;
  logic [AW-1:0] rsp_ram_addr;

  always #5 clk = ~clk;

  legacy_mem_router #(.ADDR_W(AW), .TOLM(TOLM_TB), .HIGH_END(HEND_TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .smm(smm), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .rsp_valid(rsp_valid), .rsp_tgt(rsp_tgt),
    .rsp_ram_addr(rsp_ram_addr), .rsp_wr_drop(rsp_wr_drop)
  );

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic [7:0] m_cfg [8];

  function automatic void model(input logic [39:0] a, input logic w,
                                output logic [1:0] t, output logic d,
                                output logic [39:0] ra);
    longint unsigned ad = 64'(a);
    int att = -1;
    t = 2'd2; d = 1'b0; ra = '0;
    if (ad >= 64'hA0000 && ad < 64'hC0000) begin
      if ((smm && m_cfg[7][3]) || m_cfg[7][6]) begin t = 2'd1; ra = a; end
    end else if (ad >= 64'hC0000 && ad < 64'hF0000) begin
      int k = int'((ad - 64'hC0000) / 64'h4000);
      att = (k % 2 == 0) ? int'(m_cfg[1 + k/2][1:0]) : int'(m_cfg[1 + k/2][5:4]);
    end else if (ad >= 64'hF0000 && ad < 64'h100000) begin
      att = int'(m_cfg[0][5:4]);
    end else if (ad < 64'(TOLM_TB)) begin
      t = 2'd1; ra = a;
    end else if (ad < G4) begin
      t = 2'd2;
    end else if (ad < 64'(HEND_TB)) begin
      t = 2'd1; ra = 40'(ad - G4 + 64'(TOLM_TB));
    end
    if (att == 3) begin t = 2'd1; ra = a; end
    else if (att == 1) begin
      if (w) begin t = 2'd0; d = 1'b1; end
      else   begin t = 2'd1; ra = a; end
    end
  endfunction

  task automatic cmp(input string tag, input logic ev, input logic [1:0] et,
                     input logic ed, input logic [39:0] ea);
    n_tests++;
    if (rsp_valid !== ev || rsp_tgt !== et || rsp_wr_drop !== ed || rsp_ram_addr !== ea) begin
      n_fail++;
      $display("FAIL %s: got v=%0b t=%0d d=%0b a=%h exp v=%0b t=%0d d=%0b a=%h",
               tag, rsp_valid, rsp_tgt, rsp_wr_drop, rsp_ram_addr, ev, et, ed, ea);
    end
  endtask

  task automatic do_req(input logic [39:0] a, input logic w, input string tag);
    logic [1:0] et; logic ed; logic [39:0] ea;
    model(a, w, et, ed, ea);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    cmp(tag, 1'b1, et, ed, ea);
  endtask

  task automatic do_idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    cmp(tag, 1'b0, 2'd0, 1'b0, '0);
  endtask

  task automatic cfg_wr(input logic [2:0] i, input logic [7:0] v);
    cfg_we = 1'b1; cfg_idx = i; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_cfg[i] = v;
  endtask

  task automatic req_with_cfg(input logic [39:0] a, input logic [2:0] i,
                              input logic [7:0] v, input string tag);
    logic [1:0] et; logic ed; logic [39:0] ea;
    model(a, 1'b0, et, ed, ea);
    cfg_we = 1'b1; cfg_idx = i; cfg_data = v;
    req_valid = 1'b1; req_addr = a; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    m_cfg[i] = v;
    cmp(tag, 1'b1, et, ed, ea);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < 8; i++) m_cfg[i] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    smm = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 reset idle", 1'b0, 2'd0, 1'b0, '0);
    do_req(40'hA0000, 1'b0, "R1 vga after reset");
    do_req(40'hC0000, 1'b0, "R1 rom window after reset");
    do_req(40'hF0000, 1'b1, "R1 bios after reset");
    do_idle("R2 idle after request");

    do_req(40'h1234, 1'b0, "R3 low ram");
    do_req(40'h9FFFF, 1'b1, "R3 below vga");
    do_req(40'h100000, 1'b0, "R3 above 1M");
    do_req(TOLM_TB - 1, 1'b0, "R3 top of low");
    do_req(TOLM_TB, 1'b0, "R4 hole start");
    do_req(40'hFFFF_FFFF, 1'b1, "R4 hole end");
    do_req(40'h01_0000_0000, 1'b0, "R5 4G remap");
    do_req(40'h01_0000_0100, 1'b1, "R5 high offset");
    do_req(HEND_TB - 1, 1'b0, "R5 last high");
    do_req(HEND_TB, 1'b0, "R5 past end");
    do_req(40'hFF_FFFF_FFFF, 1'b0, "R5 top address");

    cfg_wr(3'd1, 8'h13);
    do_req(40'hC0000, 1'b1, "R6 rw write");
    do_req(40'hC3FFF, 1'b0, "R6 rw read");
    do_req(40'hC4000, 1'b0, "R6 ro read");
    do_req(40'hC4000, 1'b1, "R7 ro write dropped");
    do_idle("R2 idle after drop");
    cfg_wr(3'd1, 8'hCC);
    do_req(40'hC0000, 1'b0, "R8 unused bits even");
    do_req(40'hC4000, 1'b0, "R8 unused bits odd");
    cfg_wr(3'd0, 8'h03);
    do_req(40'hF8000, 1'b0, "R8 bios ignores low bits");
    cfg_wr(3'd0, 8'h30);
    do_req(40'hFFFFF, 1'b1, "R8 bios rw");
    cfg_wr(3'd6, 8'h21);
    do_req(40'hE8000, 1'b1, "R7 window10 ro write");
    do_req(40'hE8000, 1'b0, "R6 window10 ro read");
    do_req(40'hEC000, 1'b0, "R6 window11 code2 pci");
    cfg_wr(3'd3, 8'h30);
    do_req(40'hD4000, 1'b0, "R8 window5 odd field");
    do_req(40'hD0000, 1'b0, "R8 window4 even field");

    cfg_wr(3'd7, 8'h08);
    do_req(40'hA0000, 1'b0, "R9 smram closed without smm");
    smm = 1'b1;
    do_req(40'hBFFFF, 1'b1, "R9 smram open in smm");
    cfg_wr(3'd7, 8'h00);
    do_req(40'hA0000, 1'b0, "R9 smm without enable");
    smm = 1'b0;
    cfg_wr(3'd7, 8'h40);
    do_req(40'hB0000, 1'b1, "R9 smram forced open");

    req_with_cfg(40'hDC000, 3'd4, 8'h30, "R10 same cycle uses old");
    do_req(40'hDC000, 1'b0, "R10 next cycle uses new");
    req_with_cfg(40'hA0000, 3'd7, 8'h00, "R10 smram same cycle old");
    do_req(40'hA0000, 1'b0, "R10 smram next cycle new");

    lcg = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      logic [39:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      case (lcg[31:30])
        2'd0: a = {20'h0, lcg[19:0]};
        2'd1: a = {8'h0, lcg[31:0]};
        2'd2: a = {7'h0, 1'b1, lcg[29:0], 2'b00};
        default: a = {lcg[7:0], lcg[31:0]};
      endcase
      if (lcg[3:0] == 4'd0) cfg_wr(lcg[14:12], lcg[27:20]);
      smm = lcg[5];
      do_req(a, lcg[9], "R6 R9 R5 sweep");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule